// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block forms the sixteen syndromes of a received Reed-Solomon word of 255 eight-bit symbols, whose last sixteen symbols are check symbols, over GF(2^8) with field polynomial 0x11D. It sits at the front of a decoder. Received symbols enter one per accepted cycle, highest-degree coefficient first. A start flag marks the first symbol of a word. Sixteen accumulators run side by side. Each applies Horner's rule to the incoming polynomial with its own fixed power of alpha as the multiplier. Accumulator i therefore ends the word holding R(alpha^i).

When the final symbol of a word has been taken in, the block registers all sixteen values, raises a done pulse for one cycle, and sets an error flag if any syndrome differs from zero. These results stay on the outputs until the next word completes. The decoding stages that follow can therefore read them at their own pace while the next word streams in.

Top module: `rs_syndrome_calc`

## Requirements
- R1: While reset is high, and in the cycle after it, `syn_done` and `syn_err` are 0 and every syndrome output is 0. A reset in the middle of a word abandons that word, and no result is produced for it.
- R2: For a word with coefficients r_254..r_0, delivered r_254 first, the field `syn_out[8*i+7:8*i]` (i = 0..15) equals the sum over j of r_j·alpha^(i·j). This is computed in GF(2^8), where alpha = 0x02 and the field polynomial is 0x11D.
- R3: For a valid codeword of the generator with roots alpha^0..alpha^15, every syndrome is 0 and `syn_err` is 0.
- R4: `syn_err` is 1 exactly when at least one presented syndrome is nonzero.
- R5: `syn_done` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the 255th symbol of a word.
- R6: Between two done pulses, `syn_out` and `syn_err` do not change, even while another word is being received.
- R7: A cycle with `in_valid` low neither advances the symbol count nor changes any accumulator. Gaps inside a word leave the result unchanged.
- R8: A symbol with `in_start` high always begins a new word, even if a word is already in progress. The partial word is discarded.
- R9: While no word is in progress, symbols with `in_valid` high and `in_start` low are ignored. They produce no done pulse and no output change.
- R10: A start symbol in the same cycle as the previous word's done pulse is accepted as the first symbol of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A received symbol is present this cycle |
| in_start | input | 1 | The present symbol is the first (highest-degree) symbol of a word |
| in_sym | input | 8 | Received symbol |
| syn_out | output | 128 | Syndromes S0..S15, S_i in bits 8i+7..8i |
| syn_done | output | 1 | One-cycle pulse: new syndromes are presented |
| syn_err | output | 1 | At least one presented syndrome is nonzero |

## Verification
Two functions can fall in the same cycle: presenting a finished word and accepting the first symbol of the next one. The bench provokes this by driving a start symbol on the very cycle in which `syn_done` is high. It then requires two things. At that sample point the outputs must still carry the first word's syndromes. When the second word completes, its syndromes must match the reference model, which shows that the first accumulator load was not lost to the capture. A second overlap occurs when a fresh start arrives while a partial word is in progress. There the bench judges that the output reflects only the new word and that exactly one done pulse is produced.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  // Shift-and-add product in GF(2^sw) reduced by poly (sw <= 16).
  function automatic logic [15:0] gf_mul(input logic [15:0] a, input logic [15:0] b,
                                         input int sw, input logic [16:0] poly);
    logic [16:0] r;
    r = '0;
    for (int k = 15; k >= 0; k--) begin
      if (k < sw) begin
        r = r << 1;
        if (r[sw]) r = r ^ poly;
        if (b[k]) r = r ^ {1'b0, a};
      end
    end
    return r[15:0];
  endfunction

  // alpha^e where alpha is the element x (0x2).
  function automatic logic [15:0] gf_alpha_pow(input int e, input int sw, input logic [16:0] poly);
    logic [15:0] r;
    r = 16'd1;
    for (int k = 0; k < e; k++) r = gf_mul(r, 16'd2, sw, poly);
    return r;
  endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
// Multiplier by the constant alpha^EXP: an XOR matrix fixed at elaboration.
module rs_gf_cmul #(
  parameter int          SW   = 8,
  parameter logic [SW:0] POLY = 9'h11D,
  parameter int          EXP  = 0
) (
  input  logic [SW-1:0] din,
  output logic [SW-1:0] dout
);
  import rs_syn_pkg::*;

  localparam logic [16:0] POLY17 = 17'(POLY);
  localparam logic [15:0] KONST  = gf_alpha_pow(EXP, SW, POLY17);

  logic [SW-1:0] part [SW];

  for (genvar j = 0; j < SW; j++) begin : g_col
    localparam logic [SW-1:0] COL = SW'(gf_mul(KONST, 16'(1 << j), SW, POLY17));
    assign part[j] = din[j] ? COL : '0;
  end

  always_comb begin
    dout = '0;
    for (int j = 0; j < SW; j++) dout = dout ^ part[j];
  end
endmodule

// File: rtl/rs_syn_cell.sv
// One Horner evaluator: acc <- acc*alpha^EXP + sym; a start symbol loads sym.
module rs_syn_cell #(
  parameter int          SW   = 8,
  parameter logic [SW:0] POLY = 9'h11D,
  parameter int          EXP  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [SW-1:0] sym,
  output logic [SW-1:0] acc_d
);
  logic [SW-1:0] acc_q;
  logic [SW-1:0] scaled;

  rs_gf_cmul #(.SW(SW), .POLY(POLY), .EXP(EXP)) i_mul (
    .din  (acc_q),
    .dout (scaled)
  );

  assign acc_d = load ? sym : (scaled ^ sym);

  always_ff @(posedge clk) begin
    if (rst)              acc_q <= '0;
    else if (load || step) acc_q <= acc_d;
  end
endmodule

// File: rtl/rs_syn_frame.sv
// Word framing: counts accepted symbols and flags the last one (NLEN >= 2).
module rs_syn_frame #(
  parameter int NLEN = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_start,
  output logic load,
  output logic step,
  output logic last
);
  localparam int CW = $clog2(NLEN + 1);

  logic [CW-1:0] cnt;
  logic          active;

  assign load = in_valid && in_start;
  assign step = in_valid && !in_start && active;
  assign last = step && (cnt == CW'(NLEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= CW'(1);
      active <= 1'b1;
    end else if (last) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (step) begin
      cnt    <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rs_syn_nz.sv
// Zero/nonzero detector over the full syndrome vector.
module rs_syn_nz #(
  parameter int SW   = 8,
  parameter int NSYN = 16
) (
  input  logic [NSYN*SW-1:0] vec,
  output logic               any
);
  logic [NSYN-1:0] lane_nz;

  for (genvar i = 0; i < NSYN; i++) begin : g_lane
    assign lane_nz[i] = |vec[i*SW +: SW];
  end

  assign any = |lane_nz;
endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc #(
  parameter int          SW         = 8,
  parameter int          NSYN       = 16,
  parameter int          NLEN       = 255,
  parameter logic [SW:0] POLY       = 9'h11D,
  parameter int          FIRST_ROOT = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_start,
  input  logic [SW-1:0]      in_sym,
  output logic [NSYN*SW-1:0] syn_out,
  output logic               syn_done,
  output logic               syn_err
);
  localparam int VW = NSYN * SW;

  logic          load, step, last;
  logic [VW-1:0] acc_next;
  logic          nz_next;

  rs_syn_frame #(.NLEN(NLEN)) i_frame (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_start (in_start),
    .load     (load),
    .step     (step),
    .last     (last)
  );

  for (genvar i = 0; i < NSYN; i++) begin : g_cell
    rs_syn_cell #(.SW(SW), .POLY(POLY), .EXP(FIRST_ROOT + i)) i_cell (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .step  (step),
      .sym   (in_sym),
      .acc_d (acc_next[i*SW +: SW])
    );
  end

  rs_syn_nz #(.SW(SW), .NSYN(NSYN)) i_nz (
    .vec (acc_next),
    .any (nz_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_out  <= '0;
      syn_done <= 1'b0;
      syn_err  <= 1'b0;
    end else begin
      syn_done <= last;
      if (last) begin
        syn_out <= acc_next;
        syn_err <= nz_next;
      end
    end
  end
endmodule

// File: rtl/rs_syndrome_calc_chk.sv
module rs_syndrome_calc_chk #(
  parameter int SW   = 8,
  parameter int NSYN = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [NSYN*SW-1:0] syn_out,
  input logic               syn_done,
  input logic               syn_err
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!syn_done && !syn_err && syn_out == '0));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    syn_done |=> !syn_done);

  // R5
  done_after_sym_chk: assert property (@(posedge clk) disable iff (rst)
    syn_done |-> $past(in_valid));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !syn_done |-> ($stable(syn_out) && $stable(syn_err)));

  // R4
  err_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    syn_err == (syn_out != '0));
endmodule

bind rs_syndrome_calc rs_syndrome_calc_chk #(.SW(SW), .NSYN(NSYN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .syn_out  (syn_out),
  .syn_done (syn_done),
  .syn_err  (syn_err)
);

// File: tb/test_rs_syndrome_calc.sv
`timescale 1ns/1ps
module test_rs_syndrome_calc;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         v   = 1'b0;
  logic         st  = 1'b0;
  logic [7:0]   sym = 8'h00;
  logic [127:0] syn;
  logic         done, err;

  int n_total = 0, n_fail = 0, done_cnt = 0;
  int unsigned rs = 32'h1234_5678;

  int gexp [255];
  int glog [256];
  int gpoly [17];
  logic [7:0] w [255];
  logic [127:0] ref_flat;
  logic         ref_err;

  // {error count, seed, gaps}
  localparam int VEC [9][3] = '{
    '{0, 11, 0}, '{0, 23, 1}, '{1, 5, 0}, '{2, 77, 1}, '{3, 91, 0},
    '{4, 13, 0}, '{5, 200, 1}, '{8, 321, 0}, '{8, 999, 1}};

  always #5 clk = ~clk;

  rs_syndrome_calc i_rs_syndrome_calc (
    .clk(clk), .rst(rst), .in_valid(v), .in_start(st), .in_sym(sym),
    .syn_out(syn), .syn_done(done), .syn_err(err));

  always @(posedge clk) if (done === 1'b1) done_cnt++;

  function automatic int unsigned nxt();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  function automatic int gm(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 255];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic build(input int nerr, input int seed);
    int par [16];
    int pos [8];
    rs = 32'(seed) * 32'd2654435761 + 32'd1;
    for (int d = 254; d >= 16; d--) w[d] = 8'(nxt());
    for (int j = 0; j < 16; j++) par[j] = 0;
    for (int d = 254; d >= 16; d--) begin
      int fb;
      fb = int'(w[d]) ^ par[15];
      for (int j = 15; j >= 1; j--) par[j] = par[j-1] ^ gm(fb, gpoly[j]);
      par[0] = gm(fb, gpoly[0]);
    end
    for (int j = 0; j < 16; j++) w[j] = 8'(par[j]);
    for (int e = 0; e < nerr; e++) begin
      bit dup;
      do begin
        pos[e] = int'(nxt() % 255);
        dup = 1'b0;
        for (int q = 0; q < e; q++) if (pos[q] == pos[e]) dup = 1'b1;
      end while (dup);
      w[pos[e]] = w[pos[e]] ^ 8'((nxt() % 255) + 1);
    end
    ref_flat = '0;
    for (int i = 0; i < 16; i++) begin
      int s;
      s = 0;
      for (int j = 0; j < 255; j++) s ^= gm(int'(w[j]), gexp[(i * j) % 255]);
      ref_flat[i*8 +: 8] = 8'(s);
    end
    ref_err = (ref_flat != '0);
  endtask

  // Caller stands at a negedge; returns at the negedge after the last accepted symbol.
  task automatic drive(input int n, input bit gaps, input bit use_start);
    for (int k = 0; k < n; k++) begin
      int d;
      d = 254 - k;
      if (gaps && (d % 7 == 3)) begin
        v = 1'b0; st = 1'b0;
        @(negedge clk);
      end
      v = 1'b1; st = use_start && (k == 0); sym = w[d];
      @(negedge clk);
    end
  endtask

  task automatic idle_cycle();
    v = 1'b0; st = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [127:0] prev_flat;
    logic         prev_err;
    int           dc;
    int x;
    x = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = x; glog[x] = i;
      x = x << 1;
      if ((x & 256) != 0) x = x ^ 'h11D;
    end
    for (int j = 0; j < 17; j++) gpoly[j] = 0;
    gpoly[0] = 1;
    for (int r = 0; r < 16; r++) begin
      for (int j = 16; j >= 1; j--) gpoly[j] = gpoly[j-1] ^ gm(gpoly[j], gexp[r]);
      gpoly[0] = gm(gpoly[0], gexp[r]);
    end

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1", "done in reset", 128'(done), 0);
    chk(err === 1'b0, "R1", "err in reset", 128'(err), 0);
    chk(syn === '0, "R1", "syndromes in reset", syn, 0);
    rst = 1'b0;
    @(negedge clk);

    // Vector table: R2/R3/R4/R5/R7
    for (int t = 0; t < 9; t++) begin
      build(VEC[t][0], VEC[t][1]);
      dc = done_cnt;
      drive(255, VEC[t][2] != 0, 1'b1);
      chk(done === 1'b1, "R5", "done after 255th symbol", 128'(done), 1);
      if (VEC[t][0] == 0)
        chk(syn === '0 && err === 1'b0, "R3", "codeword syndromes", syn, 0);
      else
        chk(syn === ref_flat, VEC[t][2] != 0 ? "R7" : "R2", "syndromes", syn, ref_flat);
      chk(err === ref_err, "R4", "error flag", 128'(err), 128'(ref_err));
      idle_cycle();
      chk(done === 1'b0, "R5", "done one cycle", 128'(done), 0);
      @(negedge clk);
      chk(done_cnt == dc + 1, "R5", "done pulse count", 128'(done_cnt - dc), 1);
    end

    // R6: partial next word leaves outputs held
    prev_flat = syn; prev_err = err;
    build(6, 4242);
    drive(120, 1'b0, 1'b1);
    idle_cycle();
    chk(syn === prev_flat && err === prev_err, "R6", "hold during word", syn, prev_flat);

    // R8: restart over the partial word
    dc = done_cnt;
    build(3, 777);
    drive(255, 1'b0, 1'b1);
    chk(syn === ref_flat, "R8", "syndromes after restart", syn, ref_flat);
    idle_cycle();
    @(negedge clk);
    chk(done_cnt == dc + 1, "R8", "one done after restart", 128'(done_cnt - dc), 1);

    // R10: back-to-back words, start in the done cycle
    build(2, 31337);
    drive(255, 1'b0, 1'b1);
    prev_flat = ref_flat;
    chk(done === 1'b1 && syn === prev_flat, "R10", "first word at boundary", syn, prev_flat);
    build(7, 5150);
    drive(255, 1'b0, 1'b1);
    chk(done === 1'b1 && syn === ref_flat, "R10", "second word", syn, ref_flat);
    idle_cycle();

    // R9: headless symbols while idle are ignored
    prev_flat = syn; prev_err = err;
    dc = done_cnt;
    build(0, 99);
    drive(255, 1'b0, 1'b0);
    drive(60, 1'b0, 1'b0);
    idle_cycle();
    @(negedge clk);
    chk(done_cnt == dc, "R9", "no done while idle", 128'(done_cnt - dc), 0);
    chk(syn === prev_flat && err === prev_err, "R9", "outputs unchanged", syn, prev_flat);

    // R1: reset mid-word abandons it
    build(1, 64);
    drive(60, 1'b0, 1'b1);
    v = 1'b0; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(syn === '0 && err === 1'b0 && done === 1'b0, "R1", "mid-word reset", syn, 0);
    dc = done_cnt;
    drive(255, 1'b0, 1'b0);
    idle_cycle();
    @(negedge clk);
    chk(done_cnt == dc, "R1", "abandoned word gives no done", 128'(done_cnt - dc), 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule